// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the subroutine call and return operations of a stack machine that keeps a frame pointer alongside its stack pointer. A call builds a three-word frame below the current stack pointer: an empty word kept for a static-chain link, the return address, and the caller's frame pointer. When the last word is written, the stack pointer and the frame pointer both point at the saved frame pointer, and the program counter jumps to the target. A return walks the same frame upward from the frame pointer. It restores the caller's frame pointer, fetches the return address and steps past the static-chain word.

The sequencer shares a word-wide memory port with the rest of the core. The port uses a request/acknowledge handshake, and the sequencer issues one word access per state. A fault reported by memory stops the sequence at once. The architectural registers then keep their old values and an error pulse is raised in place of the completion pulse. The core holds its current PC, stack pointer and frame pointer on the inputs. It takes the new values from the outputs when the completion pulse appears.

Top module: `callret_seq`

## Requirements
- R1: After reset, newPc, newSp and newFp are 0, and busy, memReq, done and fault are 0.
- R2: A call does not write the word at curSp-4, which is kept as the static-chain slot. Its first access is a write (memWe=1) of the return address to curSp-8.
- R3: The return address is curPc+6 when regForm=0 (absolute-target form) and curPc+2 when regForm=1 (register-target form).
- R4: The second and last access of a call writes curFp to curSp-12.
- R5: In the cycle after a call's final acknowledge, newSp and newFp both equal curSp-12, newPc equals target, and done is high for exactly one cycle. At all other times the three outputs hold their values.
- R6: A return (isReturn=1) reads curFp first and then curFp+4 (memWe=0). On completion newFp is the first word read, newPc is the second word read, and newSp is curFp+12.
- R7: memReq, memAddr, memWe and memWdata stay constant from the request until memAck. Each acknowledge finishes exactly one access.
- R8: An acknowledge that carries memFault=1 ends the sequence. fault pulses for one cycle, done stays low, no further access is made, and newPc, newSp and newFp keep their previous values.
- R9: startReq is ignored while busy is high, including in the cycle of the final acknowledge.
- R10: busy rises in the cycle after an accepted startReq. It stays high until the cycle in which done or fault appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a sequence (accepted only when idle) |
| isReturn | input | 1 | 1 selects return, 0 selects call |
| regForm | input | 1 | Call form: 0 absolute target, 1 register target |
| target | input | 32 | Call target address |
| curPc | input | 32 | PC of the call instruction |
| curSp | input | 32 | Current stack pointer (register 1) |
| curFp | input | 32 | Current frame pointer (register 0) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | 32 | Word address of the access |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Access complete |
| memFault | input | 1 | Access faulted (valid with memAck) |
| memRdata | input | 32 | Read data (valid with memAck) |
| newPc | output | 32 | Committed PC |
| newSp | output | 32 | Committed stack pointer |
| newFp | output | 32 | Committed frame pointer |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle abort pulse |
| busy | output | 1 | Sequence in progress |

## Verification
A new start request and the final memory acknowledge can fall in the same cycle. The controller then sees a start while it is still finishing. The bench provokes this by holding startReq high over a whole call and releasing it only after done is seen. It judges the result by counting the accesses the memory model serves afterwards: exactly two writes and no third request, with the outputs matching the single call. A fault and a completion can also compete on the same acknowledge. Faults are placed on the last access of a call and the first access of a return, and the bench checks that only fault pulses and that the outputs keep their values.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_RA,
    ST_PUSH_FP,
    ST_POP_FP,
    ST_POP_RA
  } seqState_t;

  // which frame word the current access touches
  typedef enum logic [1:0] {
    ACC_RA_SLOT,
    ACC_FP_SLOT,
    ACC_OLD_FP,
    ACC_RET
  } accSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    latchOps;
    accSel_t accSel;
    logic    accWrite;
    logic    grabFp;
    logic    commitCall;
    logic    commitRet;
  } dpCtl_t;

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   isReturn,
  input  logic   memAck,
  input  logic   memFault,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   done,
  output logic   fault,
  output logic   busy
);

  seqState_t state, nextState;
  logic doneSet, faultSet;
  logic ackOk, ackBad;

  assign ackOk  = memAck && !memFault;
  assign ackBad = memAck && memFault;

  always_comb begin
    ctl       = '0;
    nextState = state;
    doneSet   = 1'b0;
    faultSet  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.latchOps = 1'b1;
          nextState    = isReturn ? ST_POP_FP : ST_PUSH_RA;
        end
      end
      ST_PUSH_RA: begin
        ctl.accSel   = ACC_RA_SLOT;
        ctl.accWrite = 1'b1;
        if (ackBad) begin
          nextState = ST_IDLE;
          faultSet  = 1'b1;
        end else if (ackOk) begin
          nextState = ST_PUSH_FP;
        end
      end
      ST_PUSH_FP: begin
        ctl.accSel   = ACC_FP_SLOT;
        ctl.accWrite = 1'b1;
        if (ackBad) begin
          nextState = ST_IDLE;
          faultSet  = 1'b1;
        end else if (ackOk) begin
          nextState      = ST_IDLE;
          ctl.commitCall = 1'b1;
          doneSet        = 1'b1;
        end
      end
      ST_POP_FP: begin
        ctl.accSel = ACC_OLD_FP;
        if (ackBad) begin
          nextState = ST_IDLE;
          faultSet  = 1'b1;
        end else if (ackOk) begin
          nextState  = ST_POP_RA;
          ctl.grabFp = 1'b1;
        end
      end
      ST_POP_RA: begin
        ctl.accSel = ACC_RET;
        if (ackBad) begin
          nextState = ST_IDLE;
          faultSet  = 1'b1;
        end else if (ackOk) begin
          nextState     = ST_IDLE;
          ctl.commitRet = 1'b1;
          doneSet       = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneSet;
      fault <= faultSet;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = busy;

endmodule

// File: rtl/callret_dp.sv
module callret_dp
  import callret_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              regForm,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] curFp,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic [ADDR_W-1:0] newFp
);

  localparam int STEP = WORD_W / 8;
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(STEP);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * STEP);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3 * STEP);
  localparam logic [ADDR_W-1:0] SHORT_INC = ADDR_W'(SHORT_LEN);
  localparam logic [ADDR_W-1:0] LONG_INC  = ADDR_W'(LONG_LEN);

  logic [ADDR_W-1:0] pcQ, spQ, fpQ, tgtQ;
  logic              formQ;
  logic [WORD_W-1:0] savedFpQ;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] frameBase;

  // operands captured when a sequence is accepted
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ   <= '0;
      spQ   <= '0;
      fpQ   <= '0;
      tgtQ  <= '0;
      formQ <= 1'b0;
    end else if (ctl.latchOps) begin
      pcQ   <= curPc;
      spQ   <= curSp;
      fpQ   <= curFp;
      tgtQ  <= target;
      formQ <= regForm;
    end
  end

  assign retAddr   = pcQ + (formQ ? SHORT_INC : LONG_INC);
  assign frameBase = spQ - STEP3;

  always_comb begin
    memWdata = '0;
    unique case (ctl.accSel)
      ACC_RA_SLOT: begin
        memAddr  = spQ - STEP2;
        memWdata = WORD_W'(retAddr);
      end
      ACC_FP_SLOT: begin
        memAddr  = frameBase;
        memWdata = WORD_W'(fpQ);
      end
      ACC_OLD_FP: memAddr = fpQ;
      ACC_RET:    memAddr = fpQ + STEP1;
      default:    memAddr = fpQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedFpQ <= '0;
    end else if (ctl.grabFp) begin
      savedFpQ <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc <= '0;
      newSp <= '0;
      newFp <= '0;
    end else if (ctl.commitCall) begin
      newPc <= tgtQ;
      newSp <= frameBase;
      newFp <= frameBase;
    end else if (ctl.commitRet) begin
      newPc <= ADDR_W'(memRdata);
      newSp <= fpQ + STEP3;
      newFp <= ADDR_W'(savedFpQ);
    end
  end

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              isReturn,
  input  logic              regForm,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] curFp,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memAck,
  input  logic              memFault,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSp,
  output logic [ADDR_W-1:0] newFp,
  output logic              done,
  output logic              fault,
  output logic              busy
);

  dpCtl_t ctl;

  callret_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .isReturn (isReturn),
    .memAck   (memAck),
    .memFault (memFault),
    .ctl      (ctl),
    .memReq   (memReq),
    .done     (done),
    .fault    (fault),
    .busy     (busy)
  );

  callret_dp #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .SHORT_LEN (SHORT_LEN),
    .LONG_LEN  (LONG_LEN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .regForm  (regForm),
    .target   (target),
    .curPc    (curPc),
    .curSp    (curSp),
    .curFp    (curFp),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .newPc    (newPc),
    .newSp    (newSp),
    .newFp    (newFp)
  );

  assign memWe = ctl.accWrite;

endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memAck,
  input logic [ADDR_W-1:0] newPc,
  input logic [ADDR_W-1:0] newSp,
  input logic [ADDR_W-1:0] newFp,
  input logic              done,
  input logic              fault,
  input logic              busy
);

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  p_done_not_fault_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fault));

  p_fault_keeps_regs_r8: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $stable(newPc) && $stable(newSp) && $stable(newFp));

  p_quiet_outputs_r5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(newPc) && $stable(newSp) && $stable(newFp));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy && startReq |=> busy);

  p_idle_at_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done || fault) |-> !busy);

endmodule

bind callret_seq callret_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk_i (.*);

// File: tb/callret_seq_tb.sv
module callret_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, isReturn = 1'b0, regForm = 1'b0;
  logic [AW-1:0] target = '0, curPc = '0, curSp = '0, curFp = '0;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic memAck = 1'b0, memFault = 1'b0;
  logic [DW-1:0] memRdata = '0;
  logic [AW-1:0] newPc, newSp, newFp;
  logic done, fault, busy;

  int errors = 0;
  int checks = 0;

  // memory model
  logic [DW-1:0] mem [64];
  int latency = 0;
  int waitCnt = 0;
  logic [AW-1:0] faultAddr = '1;
  int wrCnt = 0, rdCnt = 0;
  logic [AW-1:0] wrAddr [8];
  logic [AW-1:0] rdAddr [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .isReturn(isReturn),
    .regForm(regForm), .target(target), .curPc(curPc), .curSp(curSp),
    .curFp(curFp), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memFault(memFault),
    .memRdata(memRdata), .newPc(newPc), .newSp(newSp), .newFp(newFp),
    .done(done), .fault(fault), .busy(busy)
  );

  always @(posedge clk) begin
    memAck   <= 1'b0;
    memFault <= 1'b0;
    if (memReq && !memAck) begin
      if (waitCnt >= latency) begin
        waitCnt <= 0;
        memAck  <= 1'b1;
        if (memAddr == faultAddr) begin
          memFault <= 1'b1;
        end else if (memWe) begin
          mem[memAddr[7:2]] <= memWdata;
          if (wrCnt < 8) wrAddr[wrCnt] <= memAddr;
          wrCnt <= wrCnt + 1;
        end else begin
          memRdata <= mem[memAddr[7:2]];
          if (rdCnt < 8) rdAddr[rdCnt] <= memAddr;
          rdCnt <= rdCnt + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    wrCnt = 0;
    rdCnt = 0;
  endtask

  task automatic launch(input bit ret, input bit form, input logic [31:0] pc,
                        input logic [31:0] sp, input logic [31:0] fp, input logic [31:0] tgt);
    @(negedge clk);
    isReturn = ret; regForm = form; curPc = pc; curSp = sp; curFp = fp; target = tgt;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy === 1'b1, "R10 busy after start", {31'd0, busy}, 32'd1);
  endtask

  // waits for done or fault; returns 1 for done, 0 for fault, watchdog counts as fail
  task automatic waitEnd(output bit gotDone);
    gotDone = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done || fault) begin
        gotDone = done;
        return;
      end
      @(negedge clk);
    end
    check(1'b0, "watchdog", 32'd0, 32'd1);
  endtask

  task automatic testReset();
    check(newPc === 0 && newSp === 0 && newFp === 0, "R1 outputs zero", newPc | newSp | newFp, 32'd0);
    check(!busy && !memReq && !done && !fault, "R1 controls idle",
          {28'd0, busy, memReq, done, fault}, 32'd0);
  endtask

  task automatic testCallAbs();
    bit d;
    latency = 1;
    mem[31] = 32'hDEAD_BEEF;  // word 0x7C: static-chain slot
    clearLog();
    launch(1'b0, 1'b0, 32'h100, 32'h80, 32'h40, 32'h200);
    waitEnd(d);
    check(d, "R5 call done", {31'd0, d}, 32'd1);
    check(wrCnt == 2 && rdCnt == 0, "R7 two writes", wrCnt, 32'd2);
    check(wrAddr[0] === 32'h78, "R2 first write addr", wrAddr[0], 32'h78);
    check(mem[30] === 32'h106, "R3 absolute return addr", mem[30], 32'h106);
    check(mem[31] === 32'hDEAD_BEEF, "R2 slot untouched", mem[31], 32'hDEAD_BEEF);
    check(wrAddr[1] === 32'h74 && mem[29] === 32'h40, "R4 saved fp", mem[29], 32'h40);
    check(newSp === 32'h74 && newFp === 32'h74, "R5 sp fp equal", newFp, 32'h74);
    check(newPc === 32'h200, "R5 pc target", newPc, 32'h200);
    @(negedge clk);
    check(!done, "R5 done one cycle", {31'd0, done}, 32'd0);
    check(!busy, "R10 idle after done", {31'd0, busy}, 32'd0);
  endtask

  task automatic testCallReg();
    bit d;
    latency = 0;
    clearLog();
    launch(1'b0, 1'b1, 32'h300, 32'hC0, 32'h90, 32'h500);
    waitEnd(d);
    check(d && mem[46] === 32'h302, "R3 register-form return addr", mem[46], 32'h302);
    check(mem[45] === 32'h90, "R4 saved fp reg form", mem[45], 32'h90);
    check(newSp === 32'hB4 && newFp === 32'hB4 && newPc === 32'h500, "R5 reg call outputs", newSp, 32'hB4);
  endtask

  task automatic testReturn();
    bit d;
    latency = 2;
    clearLog();
    // frame at 0x74 built by the absolute call
    launch(1'b1, 1'b0, 32'h0, 32'h74, 32'h74, 32'h0);
    waitEnd(d);
    check(d, "R6 return done", {31'd0, d}, 32'd1);
    check(rdCnt == 2 && wrCnt == 0, "R6 two reads", rdCnt, 32'd2);
    check(rdAddr[0] === 32'h74 && rdAddr[1] === 32'h78, "R6 read order", rdAddr[1], 32'h78);
    check(newFp === 32'h40, "R6 restored fp", newFp, 32'h40);
    check(newPc === 32'h106, "R6 return pc", newPc, 32'h106);
    check(newSp === 32'h80, "R6 sp skips slot", newSp, 32'h80);
  endtask

  task automatic testFaultCall();
    bit d;
    latency = 1;
    faultAddr = 32'h34;
    clearLog();
    launch(1'b0, 1'b0, 32'h700, 32'h40, 32'h20, 32'h900);
    waitEnd(d);
    check(!d && fault, "R8 call fault pulse", {31'd0, fault}, 32'd1);
    check(newPc === 32'h106 && newSp === 32'h80 && newFp === 32'h40, "R8 regs kept", newPc, 32'h106);
    repeat (6) @(negedge clk);
    check(wrCnt == 1 && !memReq && !fault, "R8 no access after fault", wrCnt, 32'd1);
    faultAddr = '1;
  endtask

  task automatic testFaultRet();
    bit d;
    latency = 0;
    faultAddr = 32'hB4;
    clearLog();
    launch(1'b1, 1'b0, 32'h0, 32'hB4, 32'hB4, 32'h0);
    waitEnd(d);
    check(!d && fault, "R8 return fault pulse", {31'd0, fault}, 32'd1);
    repeat (6) @(negedge clk);
    check(rdCnt == 0 && newPc === 32'h106 && newFp === 32'h40, "R8 return regs kept", newPc, 32'h106);
    faultAddr = '1;
  endtask

  // start held high through the whole call, including the final-ack cycle
  task automatic testBusyStart();
    bit gotDone;
    latency = 2;
    clearLog();
    @(negedge clk);
    isReturn = 1'b0; regForm = 1'b1; curPc = 32'h10; curSp = 32'hF0; curFp = 32'hE0; target = 32'h44;
    startReq = 1'b1;
    @(negedge clk);
    isReturn = 1'b1;  // would select a return if re-accepted
    gotDone = 1'b0;
    for (int i = 0; i < 200 && !gotDone; i++) begin
      if (done) gotDone = 1'b1;
      else @(negedge clk);
    end
    startReq = 1'b0;
    check(gotDone, "R9 single call done", {31'd0, gotDone}, 32'd1);
    repeat (10) @(negedge clk);
    check(wrCnt == 2 && rdCnt == 0, "R9 no second sequence", wrCnt + rdCnt, 32'd2);
    check(!busy && !memReq, "R9 idle after", {30'd0, busy, memReq}, 32'd0);
    check(newPc === 32'h44 && newSp === 32'hE4 && newFp === 32'hE4, "R9 outputs of one call", newSp, 32'hE4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCallAbs();
    testCallReg();
    testReturn();
    testFaultCall();
    testFaultRet();
    testBusyStart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule